// File: doc/BRIEF.md
# Windowed Pixel-Memory Write Path

This block sits between the host side of a small graphics display controller and its pixel memory. It keeps a 16-bit address counter whose upper byte is the row (00h to AFh) and whose lower byte is the column (00h to 83h), so the last legal address is AF83h. Four 8-bit bounds define a rectangular window: a start and an end on the column byte and a start and an end on the row byte. Software is responsible for keeping all four bounds inside the address space.

A register port accepts an 8-bit index and a 16-bit value. It loads the address counter, the bit-level write mask, the window bounds and the stepping mode. A separate pixel port carries reads and writes. Every pixel write is a read-modify-write against a synchronous RAM with one cycle of read latency. Where a mask bit is 1, the stored bit keeps its old value. After each write the counter advances inside the window, along the axis and in the directions that the mode selects. A pixel read returns the word at the counter and leaves the counter where it was.

Top module: `gram_wr_path`

## Requirements
- R1: After reset the mask is 0000h, the counter is 0000h, the window spans columns 00h..83h and rows 00h..AFh, the mode is column-first with both axes counting up, and busy, ram_we and px_rvalid are low.
- R2: A register write to index 21h loads reg_wdata into the counter. ram_addr always shows the counter, with the row in bits 15:8 and the column in bits 7:0.
- R3: Index 20h holds the write mask. Each written word is (old & mask) | (new & ~mask), so a 1 in the mask keeps the stored bit.
- R4: A pixel write accepted in cycle N drives ram_re with ram_addr in cycle N. In cycle N+1 it drives ram_we with the merged word at the same address, with busy high. busy is never high for two cycles in a row.
- R5: While busy is high, pixel and register strobes are ignored. When px_we and px_re arrive together, the write is taken and the read is dropped.
- R6: A pixel read accepted in cycle N drives ram_re in cycle N. px_rvalid is high in cycle N+1, and px_rdata then holds the word at the counter. A read never moves the counter.
- R7: Index 10h sets the mode: bit 0 = 1 makes the column count up, bit 1 = 1 makes the row count up, and bit 2 = 0 selects column-first stepping. In column-first mode each write steps the column. When the column is at its far bound, it reloads to the opposite bound and the row steps once.
- R8: With mode bit 2 = 1 the row steps first. When the row is at its far bound, it reloads to the opposite bound and the column steps once.
- R9: A counting-up axis moves from its start bound toward its end bound and is at its far bound when its value is at or above the end. A counting-down axis moves from the end toward the start and is at its far bound when its value is at or below the start.
- R10: When both axes reach their far bounds on the same write, the counter returns to the window's starting corner for the current directions. In the full-screen window, a write at AF83h going up on both axes is followed by 0000h.
- R11: Index 40h sets the column bounds (start in bits 7:0, end in bits 15:8). Index 41h sets the row bounds in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 16 | Register write value |
| px_we | input | 1 | Pixel write strobe |
| px_re | input | 1 | Pixel read strobe |
| px_wdata | input | 16 | Pixel write data |
| px_rdata | output | 16 | Pixel read data, valid with px_rvalid |
| px_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Merge cycle of a write in progress |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address (row byte high, column byte low) |
| ram_wdata | output | 16 | RAM write data (merged word) |
| ram_rdata | input | 16 | RAM read data, one cycle after ram_re |

## Verification
The bench sweeps every address of the full-screen window. A counter whose row never carries, or that wraps before or after AF83h, gives a wrong address at the first column or row boundary. Eight stepping modes are then run through a small 4 by 3 window for more than two laps. This catches a wrong primary axis, reloads to the wrong bound and a lost return to the starting corner. Masked writes are read back, which exposes an inverted or ignored mask. Strobes held through the merge cycle and a write arriving together with a read show whether a second access or a counter reload could slip in while the block is busy, and whether a read moves the counter.

// File: rtl/gram_pkg.sv
`timescale 1ns/1ps
// Package gram_pkg
// Shared register indices, stepping-mode layout and controller states for
// the windowed pixel-memory write path. Assumes 8-bit register indices.
package gram_pkg;

    localparam logic [7:0] IDX_MODE = 8'h10;   // stepping mode
    localparam logic [7:0] IDX_MASK = 8'h20;   // bit write mask
    localparam logic [7:0] IDX_ADDR = 8'h21;   // address counter load
    localparam logic [7:0] IDX_HWIN = 8'h40;   // column bounds {end,start}
    localparam logic [7:0] IDX_VWIN = 8'h41;   // row bounds {end,start}

    typedef struct packed {
        logic row_first;   // mode bit 2
        logic row_up;      // mode bit 1
        logic col_up;      // mode bit 0
    } step_mode_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_MERGE = 1'b1
    } rmw_state_t;

endpackage

// File: rtl/gram_axis_step.sv
`timescale 1ns/1ps
// Module gram_axis_step
// One coordinate of the address counter. It reports whether the coordinate
// sits at its far bound for the current direction, and it gives the value
// after one step: the opposite bound when at the far bound, otherwise +/-1.
// Assumes lo <= hi. The caller decides when the step is taken.
module gram_axis_step #(
    parameter int CRD_W = 8
) (
    input  logic [CRD_W-1:0] pos,
    input  logic [CRD_W-1:0] lo,
    input  logic [CRD_W-1:0] hi,
    input  logic             up,
    input  logic             adv,
    output logic             at_edge,
    output logic [CRD_W-1:0] nxt
);

    localparam logic [CRD_W-1:0] ONE = {{(CRD_W-1){1'b0}}, 1'b1};

    // Far-bound test, independent of the step request
    always_comb begin
        at_edge = up ? (pos >= hi) : (pos <= lo);
    end

    // Next coordinate: hold, reload to the opposite bound, or move by one
    always_comb begin
        if (!adv)
            nxt = pos;
        else if (at_edge)
            nxt = up ? lo : hi;
        else
            nxt = up ? (pos + ONE) : (pos - ONE);
    end

endmodule

// File: rtl/gram_cfg_regs.sv
`timescale 1ns/1ps
// Module gram_cfg_regs
// Configuration registers: write mask, stepping mode and window bounds.
// Writes arrive already qualified by the caller (not busy). Index 21h, the
// counter load, is handled by the top and ignored here.
module gram_cfg_regs
    import gram_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CRD_W    = 8,
    parameter int COL_LAST = 'h83,
    parameter int ROW_LAST = 'hAF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wmask,
    output step_mode_t        mode,
    output logic [CRD_W-1:0]  col_lo,
    output logic [CRD_W-1:0]  col_hi,
    output logic [CRD_W-1:0]  row_lo,
    output logic [CRD_W-1:0]  row_hi
);

    localparam logic [CRD_W-1:0] COL_END = CRD_W'(COL_LAST);
    localparam logic [CRD_W-1:0] ROW_END = CRD_W'(ROW_LAST);

    logic unused_bits;
    assign unused_bits = ^wr_data[DATA_W-1:3];

    // Register file update with full-screen reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmask  <= '0;
            mode   <= '{row_first: 1'b0, row_up: 1'b1, col_up: 1'b1};
            col_lo <= '0;
            col_hi <= COL_END;
            row_lo <= '0;
            row_hi <= ROW_END;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_MASK: wmask <= wr_data;
                IDX_MODE: mode  <= step_mode_t'(wr_data[2:0]);
                IDX_HWIN: begin
                    col_lo <= wr_data[CRD_W-1:0];
                    col_hi <= wr_data[2*CRD_W-1:CRD_W];
                end
                IDX_VWIN: begin
                    row_lo <= wr_data[CRD_W-1:0];
                    row_hi <= wr_data[2*CRD_W-1:CRD_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gram_rmw_ctrl.sv
`timescale 1ns/1ps
// Module gram_rmw_ctrl
// Sequencer for pixel accesses. A write takes two cycles: a read of the old
// word, then a write of the merged word. A read takes one cycle to issue,
// with its data flagged valid in the next cycle. Strobes arriving during the
// merge cycle are dropped, and a write wins over a read in the same cycle.
module gram_rmw_ctrl
    import gram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic px_we,
    input  logic px_re,
    output logic take_wr,
    output logic ram_re,
    output logic commit,
    output logic busy,
    output logic rvalid
);

    rmw_state_t state;
    logic       take_rd;

    // Acceptance decode from the current state
    always_comb begin
        take_wr = (state == ST_IDLE) && px_we;
        take_rd = (state == ST_IDLE) && px_re && !px_we;
        ram_re  = take_wr || take_rd;
        commit  = (state == ST_MERGE);
        busy    = (state == ST_MERGE);
    end

    // State register: an accepted write spends one cycle in the merge state
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (take_wr)
            state <= ST_MERGE;
        else
            state <= ST_IDLE;
    end

    // Read-data valid flag, one cycle after a read is issued
    always_ff @(posedge clk) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else
            rvalid <= take_rd;
    end

endmodule

// File: rtl/gram_wr_path.sv
`timescale 1ns/1ps
// Module gram_wr_path (top)
// Pixel-memory write path: address counter stepping inside a rectangular
// window, masked read-modify-write and plain reads against a synchronous RAM
// with one cycle of read latency. The counter is {row, column}. Assumes the
// window bounds lie inside the address space and that lo <= hi on each axis.
module gram_wr_path
    import gram_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CRD_W    = 8,
    parameter int COL_LAST = 'h83,
    parameter int ROW_LAST = 'hAF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [7:0]           reg_idx,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 px_we,
    input  logic                 px_re,
    input  logic [DATA_W-1:0]    px_wdata,
    output logic [DATA_W-1:0]    px_rdata,
    output logic                 px_rvalid,
    output logic                 busy,
    output logic                 ram_re,
    output logic                 ram_we,
    output logic [2*CRD_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]    ram_wdata,
    input  logic [DATA_W-1:0]    ram_rdata
);

    localparam int ADDR_W = 2 * CRD_W;
    localparam int N_AXES = 2;   // 0 = column, 1 = row

    logic              reg_ok;
    logic              ac_load;
    logic              take_wr;
    logic              commit;
    logic [ADDR_W-1:0] ac;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] wmask;
    step_mode_t        mode;
    logic [CRD_W-1:0]  col_lo, col_hi, row_lo, row_hi;

    logic [CRD_W-1:0]  ax_pos  [N_AXES];
    logic [CRD_W-1:0]  ax_lo   [N_AXES];
    logic [CRD_W-1:0]  ax_hi   [N_AXES];
    logic [CRD_W-1:0]  ax_nxt  [N_AXES];
    logic              ax_up   [N_AXES];
    logic              ax_adv  [N_AXES];
    logic              ax_edge [N_AXES];

    // Register writes are honoured only outside the merge cycle
    always_comb begin
        reg_ok  = reg_we && !busy;
        ac_load = reg_ok && (reg_idx == IDX_ADDR);
    end

    gram_cfg_regs #(
        .DATA_W   (DATA_W),
        .CRD_W    (CRD_W),
        .COL_LAST (COL_LAST),
        .ROW_LAST (ROW_LAST)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_ok),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata),
        .wmask   (wmask),
        .mode    (mode),
        .col_lo  (col_lo),
        .col_hi  (col_hi),
        .row_lo  (row_lo),
        .row_hi  (row_hi)
    );

    gram_rmw_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .px_we   (px_we),
        .px_re   (px_re),
        .take_wr (take_wr),
        .ram_re  (ram_re),
        .commit  (commit),
        .busy    (busy),
        .rvalid  (px_rvalid)
    );

    // Map counter bytes and window bounds onto the per-axis stepping inputs
    always_comb begin
        ax_pos[0] = ac[CRD_W-1:0];
        ax_pos[1] = ac[ADDR_W-1:CRD_W];
        ax_lo[0]  = col_lo;
        ax_hi[0]  = col_hi;
        ax_lo[1]  = row_lo;
        ax_hi[1]  = row_hi;
        ax_up[0]  = mode.col_up;
        ax_up[1]  = mode.row_up;
        // The primary axis steps on every write, the other only on a reload
        ax_adv[0] = commit && (mode.row_first ? ax_edge[1] : 1'b1);
        ax_adv[1] = commit && (mode.row_first ? 1'b1 : ax_edge[0]);
    end

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        gram_axis_step #(
            .CRD_W (CRD_W)
        ) i_step (
            .pos     (ax_pos[g]),
            .lo      (ax_lo[g]),
            .hi      (ax_hi[g]),
            .up      (ax_up[g]),
            .adv     (ax_adv[g]),
            .at_edge (ax_edge[g]),
            .nxt     (ax_nxt[g])
        );
    end

    // Address counter: direct load from the register port, or step after a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ac <= '0;
        else if (ac_load)
            ac <= reg_wdata[ADDR_W-1:0];
        else if (commit)
            ac <= {ax_nxt[1], ax_nxt[0]};
    end

    // Hold the new pixel word until the old word returns from the RAM
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_data <= '0;
        else if (take_wr)
            pend_data <= px_wdata;
    end

    // RAM-side outputs and the bitwise merge of old and new words
    always_comb begin
        ram_addr  = ac;
        ram_we    = commit;
        ram_wdata = (ram_rdata & wmask) | (pend_data & ~wmask);
        px_rdata  = ram_rdata;
    end

endmodule

// File: rtl/gram_wr_path_chk.sv
`timescale 1ns/1ps
// Module gram_wr_path_chk
// Property checker for gram_wr_path, attached with a bind statement below.
// It watches the ports and the internal mask register.
module gram_wr_path_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              px_we,
    input logic              px_re,
    input logic              px_rvalid,
    input logic              busy,
    input logic              ram_re,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] ram_rdata,
    input logic [DATA_W-1:0] wmask
);

    AST_WRITE_MERGES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && px_we) |=> (ram_we && busy));                                  // R4
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);                                                         // R4
    AST_MERGE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && px_we) |=> (ram_addr == $past(ram_addr)));                     // R4
    AST_MASKED_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (((ram_wdata ^ ram_rdata) & wmask) == '0));                   // R3
    AST_NO_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ram_re);                                                       // R5
    AST_WRITE_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && px_we) |=> !px_rvalid);                                        // R5
    AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && px_re && !px_we) |=> px_rvalid);                               // R6
    AST_READ_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && px_re && !px_we && !reg_we) |=> (ram_addr == $past(ram_addr)));  // R6

endmodule

bind gram_wr_path gram_wr_path_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (2 * CRD_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .px_we     (px_we),
    .px_re     (px_re),
    .px_rvalid (px_rvalid),
    .busy      (busy),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .wmask     (wmask)
);

// File: tb/test_gram_wr_path.sv
`timescale 1ns/1ps
// Bench for gram_wr_path: full-screen sweep, small-window sweeps in all
// eight stepping modes, masked writes with readback, busy and priority cases.
module test_gram_wr_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic        px_we = 1'b0;
    logic        px_re = 1'b0;
    logic [15:0] px_wdata = '0;
    logic [15:0] px_rdata;
    logic        px_rvalid;
    logic        busy;
    logic        ram_re;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata;

    int n_chk = 0;
    int n_err = 0;
    int hs = 0, he = 'h83, vs = 0, ve = 'hAF;
    logic [15:0] mask_m = '0;
    logic [15:0] mem [1024];

    always #10 clk = ~clk;

    gram_wr_path i_gram_wr_path (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .px_we(px_we), .px_re(px_re), .px_wdata(px_wdata),
        .px_rdata(px_rdata), .px_rvalid(px_rvalid), .busy(busy), .ram_re(ram_re),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    function automatic int midx(logic [15:0] a);
        return int'({a[12:8], a[4:0]});
    endfunction

    // Synchronous RAM model with one cycle of read latency
    always @(posedge clk) begin
        if (ram_we) mem[midx(ram_addr)] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[midx(ram_addr)];
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected address of the k-th write after starting at the window corner
    function automatic logic [15:0] exp_addr(int k, int m);
        int w = he - hs + 1;
        int h = ve - vs + 1;
        int kk = k % (w * h);
        int co, ro, col, row;
        if (m[2]) begin
            ro = kk % h;
            co = (kk / h) % w;
        end else begin
            co = kk % w;
            ro = (kk / w) % h;
        end
        col = m[0] ? hs + co : he - co;
        row = m[1] ? vs + ro : ve - ro;
        return {row[7:0], col[7:0]};
    endfunction

    task automatic set_reg(logic [7:0] idx, logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        if (idx == 8'h20) mask_m = val;
    endtask

    task automatic do_write(logic [15:0] d, logic [15:0] exp, string req);
        logic [15:0] old;
        @(negedge clk);
        px_we = 1'b1; px_wdata = d;
        @(negedge clk);
        px_we = 1'b0;
        old = mem[midx(exp)];
        chk(ram_we && busy, "R4", "merge-cycle write strobe", {30'd0, ram_we, busy}, 32'h3);
        chk(ram_addr == exp, req, "write address", ram_addr, exp);
        chk(ram_wdata == ((old & mask_m) | (d & ~mask_m)), "R3", "merged word",
            ram_wdata, (old & mask_m) | (d & ~mask_m));
    endtask

    task automatic do_read(logic [15:0] exp, string req);
        @(negedge clk);
        px_re = 1'b1;
        @(negedge clk);
        px_re = 1'b0;
        chk(px_rvalid && px_rdata == exp, req, "read data", px_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !ram_we && !px_rvalid, "R1", "idle outputs",
            {29'd0, busy, ram_we, px_rvalid}, 32'd0);
        chk(ram_addr == 16'h0000, "R1", "reset counter", ram_addr, 16'h0000);

        // R1/R10 full-screen sweep in the reset mode, wrap after AF83h
        for (int k = 0; k <= 132 * 176; k++) begin
            do_write(k[15:0] ^ 16'h5A5A, exp_addr(k, 3), (k == 132 * 176) ? "R10" : "R1");
        end

        // R2 address load, R3 masking, R6 read leaves the counter alone
        set_reg(8'h21, 16'h0305);
        do_write(16'hA5A5, 16'h0305, "R2");
        set_reg(8'h20, 16'hFF00);
        set_reg(8'h21, 16'h0305);
        do_write(16'h1234, 16'h0305, "R3");
        set_reg(8'h21, 16'h0305);
        do_read(16'hA534, "R3");
        set_reg(8'h20, 16'hF0F0);
        do_write(16'h0000, 16'h0305, "R6");
        set_reg(8'h21, 16'h0305);
        do_read(16'hA030, "R3");
        set_reg(8'h20, 16'hFFFF);
        do_write(16'h5555, 16'h0305, "R6");
        set_reg(8'h21, 16'h0305);
        do_read(16'hA030, "R3");
        set_reg(8'h20, 16'h0000);

        // R5 strobes during the merge cycle are dropped
        set_reg(8'h21, 16'h0102);
        @(negedge clk);
        px_we = 1'b1; px_wdata = 16'h1111;
        @(negedge clk);
        chk(ram_we && ram_addr == 16'h0102, "R5", "first write", ram_addr, 16'h0102);
        reg_we = 1'b1; reg_idx = 8'h21; reg_wdata = 16'h0A0A;
        @(negedge clk);
        px_we = 1'b0; reg_we = 1'b0;
        chk(!ram_we && !busy, "R5", "no second write", {30'd0, ram_we, busy}, 32'd0);
        do_write(16'h2222, 16'h0103, "R5");
        // R5 write wins over a simultaneous read
        @(negedge clk);
        px_we = 1'b1; px_re = 1'b1; px_wdata = 16'h3333;
        @(negedge clk);
        px_we = 1'b0; px_re = 1'b0;
        chk(ram_we && ram_addr == 16'h0104, "R5", "write taken", ram_addr, 16'h0104);
        @(negedge clk);
        chk(!px_rvalid, "R5", "read dropped", {31'd0, px_rvalid}, 32'd0);

        // R7/R8/R9/R10/R11 small window in all eight modes
        hs = 3; he = 6; vs = 2; ve = 4;
        set_reg(8'h40, {8'd6, 8'd3});
        set_reg(8'h41, {8'd4, 8'd2});
        for (int m = 0; m < 8; m++) begin
            logic [7:0] c0, r0;
            c0 = m[0] ? 8'(hs) : 8'(he);
            r0 = m[1] ? 8'(vs) : 8'(ve);
            set_reg(8'h10, 16'(m));
            set_reg(8'h21, {r0, c0});
            for (int k = 0; k < 26; k++) begin
                do_write(16'(k * 7 + m), exp_addr(k, m),
                         m[2] ? "R8 R9 R10 R11" : "R7 R9 R10 R11");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule